// File: doc/BRIEF.md
# Prefetch Mode Profiler with Hysteresis

This block watches four kinds of prefetch-related events and, once per epoch, decides whether a prefetch engine should run in three operating modes. The events are useful prefetches, useless prefetches, requests that found no free tracking entry, and cache conflict misses. Each event arrives as a single-cycle pulse and is counted in its own saturating counter. The modes are aggressive prefetching, entry saving and conflict avoidance.

An epoch boundary is any cycle on which the low `EPOCH_BITS` bits of a free-running cycle count input are all zero. On that cycle each mode flag is compared against two levels. A flag is raised above the upper level, dropped below the lower level, and left as it is in between. After the decision every counter is halved, so each counter acts as a decaying moving average of recent activity. The three flags are registered and feed the prefetch logic directly.

Top module: `prefetch_mode_profiler`

## Requirements
- R1: The three flags change only on the clock edge at which the low `EPOCH_BITS` bits of `cycle_count` are zero. On every other edge they hold.
- R2: At a boundary `aggressive` becomes 1 when the useful count is greater than `AGG_MULT` times the useless count.
- R3: At a boundary `aggressive` becomes 0 when the useful count is less than `AGG_MULT/2` times the useless count. When neither R2 nor R3 applies, it keeps its value.
- R4: At a boundary `save_entry` becomes 1 when the shortage count is greater than `SE_THRESH`. It becomes 0 when that count is less than `SE_THRESH/4`, and otherwise holds.
- R5: At a boundary `conflict_avoid` becomes 1 when the conflict count is greater than `CA_THRESH`. It becomes 0 when that count is less than `CA_THRESH/4`, and otherwise holds.
- R6: During reset all flags are 0, the useful and useless counts are 0, the shortage count is `SE_INIT` and the conflict count is `CA_INIT`.
- R7: At a boundary each counter is replaced by its value shifted right by one (floor), after the flags have been decided from the unshifted values.
- R8: An event pulse adds 1 to its counter. On a boundary cycle the 1 is added to the halved value.
- R9: Counters saturate at 2^`CNT_W`-1 and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_pf_useful | input | 1 | Pulse: a prefetched line was used |
| ev_pf_useless | input | 1 | Pulse: a prefetched line was not used |
| ev_entry_short | input | 1 | Pulse: no free tracking entry was available |
| ev_conflict | input | 1 | Pulse: a conflict miss was detected |
| cycle_count | input | CYC_W | Free-running cycle count |
| aggressive | output | 1 | Aggressive prefetch mode flag |
| save_entry | output | 1 | Entry saving mode flag |
| conflict_avoid | output | 1 | Conflict avoidance mode flag |

## Verification
The bench builds the block with `CNT_W`=8, `EPOCH_BITS`=4, `SE_THRESH`=40 and `CA_THRESH`=20, and drives `cycle_count` itself. With these values saturation takes a few hundred pulses, and each threshold can be crossed in either direction within a few boundaries. Both hysteresis bands can be held, and an event that coincides with a boundary decides whether a later flag drops.

// File: rtl/prefetch_mode_profiler.sv
module prefetch_mode_profiler #(
  parameter int CNT_W      = 32,
  parameter int CYC_W      = 64,
  parameter int EPOCH_BITS = 18,
  parameter int AGG_MULT   = 8,
  parameter int SE_THRESH  = 128,
  parameter int CA_THRESH  = 64,
  parameter int SE_INIT    = 64,
  parameter int CA_INIT    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_pf_useful,
  input  logic             ev_pf_useless,
  input  logic             ev_entry_short,
  input  logic             ev_conflict,
  input  logic [CYC_W-1:0] cycle_count,
  output logic             aggressive,
  output logic             save_entry,
  output logic             conflict_avoid
);

  localparam int WIDE = CNT_W + 8;
  localparam logic [CNT_W-1:0] CMAX    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] SE_HI   = CNT_W'(SE_THRESH);
  localparam logic [CNT_W-1:0] SE_LO   = CNT_W'(SE_THRESH / 4);
  localparam logic [CNT_W-1:0] CA_HI   = CNT_W'(CA_THRESH);
  localparam logic [CNT_W-1:0] CA_LO   = CNT_W'(CA_THRESH / 4);

  logic [CNT_W-1:0] cnt_good, cnt_bad, cnt_short, cnt_conf;
  logic             epoch;
  logic [WIDE-1:0]  good_w, bad_hi, bad_lo;

  assign epoch  = (cycle_count[EPOCH_BITS-1:0] == '0);
  assign good_w = WIDE'(cnt_good);
  assign bad_hi = WIDE'(cnt_bad) * WIDE'(AGG_MULT);
  assign bad_lo = WIDE'(cnt_bad) * WIDE'(AGG_MULT / 2);

  function automatic logic [CNT_W-1:0] step_cnt(input logic [CNT_W-1:0] cur,
                                                input logic ev, input logic halve);
    logic [CNT_W-1:0] base;
    base = halve ? (cur >> 1) : cur;
    return (ev && base != CMAX) ? base + CNT_ONE : base;
  endfunction

  function automatic logic hyst(input logic cur, input logic up, input logic down);
    return up ? 1'b1 : (down ? 1'b0 : cur);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_good       <= '0;
      cnt_bad        <= '0;
      cnt_short      <= CNT_W'(SE_INIT);
      cnt_conf       <= CNT_W'(CA_INIT);
      aggressive     <= 1'b0;
      save_entry     <= 1'b0;
      conflict_avoid <= 1'b0;
    end else begin
      cnt_good  <= step_cnt(cnt_good,  ev_pf_useful,   epoch);
      cnt_bad   <= step_cnt(cnt_bad,   ev_pf_useless,  epoch);
      cnt_short <= step_cnt(cnt_short, ev_entry_short, epoch);
      cnt_conf  <= step_cnt(cnt_conf,  ev_conflict,    epoch);
      if (epoch) begin
        aggressive     <= hyst(aggressive, good_w > bad_hi, good_w < bad_lo);
        save_entry     <= hyst(save_entry, cnt_short > SE_HI, cnt_short < SE_LO);
        conflict_avoid <= hyst(conflict_avoid, cnt_conf > CA_HI, cnt_conf < CA_LO);
      end
    end
  end

  AST_FLAGS_HOLD_OFF_EPOCH: assert property (@(posedge clk) disable iff (!rst_n)
    !epoch |=> $stable({aggressive, save_entry, conflict_avoid})); // R1
  AST_AGG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    epoch && good_w > bad_hi |=> aggressive); // R2
  AST_AGG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    epoch && good_w < bad_lo |=> !aggressive); // R3
  AST_SE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    epoch && cnt_short > SE_HI |=> save_entry); // R4
  AST_CA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    epoch && cnt_conf < CA_LO |=> !conflict_avoid); // R5
  AST_HALVE: assert property (@(posedge clk) disable iff (!rst_n)
    epoch && !ev_pf_useless |=> cnt_bad == ($past(cnt_bad) >> 1)); // R7
  AST_COUNT_AFTER_HALVE: assert property (@(posedge clk) disable iff (!rst_n)
    epoch && ev_conflict |=> cnt_conf == ($past(cnt_conf) >> 1) + CNT_ONE); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !epoch && cnt_good == CMAX |=> cnt_good == CMAX); // R9

endmodule

// File: tb/prefetch_mode_profiler_tb.sv
`timescale 1ns/1ps
module prefetch_mode_profiler_tb_top;
  localparam int CNT_W = 8, CYC_W = 12, EB = 4, MULT = 8, SE_T = 40, CA_T = 20;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0;
  logic e_good = 0, e_bad = 0, e_short = 0, e_conf = 0;
  logic [CYC_W-1:0] cyc = 1;
  logic agg, se, ca;
  int checks = 0, failures = 0, ep_k = 1;
  int m_good = 0, m_bad = 0, m_short = 64, m_conf = 16;
  logic x_agg = 0, x_se = 0, x_ca = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prefetch_mode_profiler #(.CNT_W(CNT_W), .CYC_W(CYC_W), .EPOCH_BITS(EB), .AGG_MULT(MULT),
    .SE_THRESH(SE_T), .CA_THRESH(CA_T), .SE_INIT(64), .CA_INIT(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_pf_useful(e_good), .ev_pf_useless(e_bad),
    .ev_entry_short(e_short), .ev_conflict(e_conf), .cycle_count(cyc),
    .aggressive(agg), .save_entry(se), .conflict_avoid(ca));

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  function automatic int sat_add(int v, logic ev);
    return (ev && v < CMAX) ? v + 1 : v;
  endfunction

  // One clock cycle; called at a negedge, returns at the next negedge.
  task automatic step(bit bnd, logic g, logic b, logic s, logic c);
    cyc = bnd ? CYC_W'(ep_k << EB) : CYC_W'((ep_k << EB) | 5);
    e_good = g; e_bad = b; e_short = s; e_conf = c;
    if (bnd) begin
      if (m_good > MULT * m_bad) x_agg = 1; else if (m_good < (MULT / 2) * m_bad) x_agg = 0;
      if (m_short > SE_T) x_se = 1; else if (m_short < SE_T / 4) x_se = 0;
      if (m_conf > CA_T) x_ca = 1; else if (m_conf < CA_T / 4) x_ca = 0;
      m_good = m_good >> 1; m_bad = m_bad >> 1; m_short = m_short >> 1; m_conf = m_conf >> 1;
      ep_k = (ep_k + 1) % 200;
    end
    m_good = sat_add(m_good, g); m_bad = sat_add(m_bad, b);
    m_short = sat_add(m_short, s); m_conf = sat_add(m_conf, c);
    @(negedge clk);
    e_good = 0; e_bad = 0; e_short = 0; e_conf = 0; cyc = CYC_W'((ep_k << EB) | 5);
  endtask

  task automatic boundary(string req, logic g = 0, logic b = 0, logic s = 0, logic c = 0);
    step(1, g, b, s, c);
    chk(req, "aggressive", agg, x_agg);
    chk(req, "save_entry", se, x_se);
    chk(req, "conflict_avoid", ca, x_ca);
  endtask

  task automatic pulse(int kind, int n);
    for (int i = 0; i < n; i++)
      step(0, kind == 0, kind == 1, kind == 2, kind == 3);
  endtask

  task automatic t_reset();
    chk("R6", "aggressive at reset", agg, 0);
    chk("R6", "save_entry at reset", se, 0);
    chk("R6", "conflict_avoid at reset", ca, 0);
    boundary("R6");
    chk("R6", "save_entry from initial count", se, 1);
  endtask

  task automatic t_saturate();
    pulse(1, 31);
    pulse(0, 300);
    boundary("R9");
    chk("R9", "aggressive after saturated count", agg, 1);
  endtask

  task automatic t_aggressive();
    pulse(1, 20);
    boundary("R3");
    pulse(0, 40);
    boundary("R3");
    pulse(0, 20);
    boundary("R2");
    pulse(1, 2);
    boundary("R3");
  endtask

  task automatic t_off_epoch();
    logic a0, s0, c0;
    bit moved = 0;
    a0 = agg; s0 = se; c0 = ca;
    for (int i = 0; i < 30; i++) begin
      step(0, 1, 1, 1, 1);
      if (agg !== a0 || se !== s0 || ca !== c0) moved = 1;
    end
    chk("R1", "flags held off boundary", moved, 0);
    boundary("R5");
    boundary("R1");
  endtask

  task automatic t_decay();
    for (int i = 0; i < 6; i++) boundary("R7");
  endtask

  task automatic t_entry_hyst();
    pulse(2, 60 - m_short);
    boundary("R4");
    boundary("R4");
    pulse(2, 18 - m_short);
    boundary("R8", 0, 0, 1, 0);
    boundary("R8");
    chk("R8", "save_entry kept by boundary event", se, 1);
    boundary("R4");
    chk("R4", "save_entry cleared below quarter", se, 0);
  endtask

  task automatic t_all_events();
    pulse(3, 25);
    boundary("R8", 1, 1, 1, 1);
    boundary("R5");
    for (int i = 0; i < 4; i++) boundary("R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_saturate();
    t_aggressive();
    t_off_epoch();
    t_decay();
    t_entry_hyst();
    t_all_events();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule